// File: doc/BRIEF.md
# Per-Pin Input Filter Bank

This block conditions the input levels of one bank of pins before the status and interrupt logic uses them. Each asynchronous pin is first brought into the system clock domain by a synchronizer. It then passes through one of three paths, chosen per pin. The first is a straight pass-through. The second is a short-glitch filter that samples on every system clock. The third is a debounce filter that samples only on a slow tick produced by a programmable divider, which is shared by all pins of the bank.

Software programs the block through a single-cycle write port. One pair of addresses sets or clears the filter-enable bit of every pin whose mask bit is 1. A second pair moves pins into debounce mode or back to glitch mode in the same way. A fifth address loads the shared divider. A combinational read port returns the enable mask, the mode mask and the divider. The slow clock arrives as a one-cycle strobe, `slow_tick`, in the system clock domain. The filtered levels and the control inputs are plain signals with no handshake, because pin levels are continuous state and not a stream of items.

Top module: `infilt_bank`

## Requirements
- R1: After reset, every filter is disabled, every pin is in glitch mode (mode bit 0), the divider reads 0 and `pin_level` is all zeros.
- R2: A write to address 0 sets, and a write to address 1 clears, the enable bit of each pin whose `wr_data` bit is 1. Other pins keep their bits. Reading address 0 returns the enable mask in bits NPINS-1:0.
- R3: A write to address 2 puts each masked pin into debounce mode (mode bit 1), and a write to address 3 puts each masked pin into glitch mode (mode bit 0). Reading address 2 returns the mode mask.
- R4: A write to address 4 keeps only the low DIV_W bits of `wr_data` as the divider. Reading address 4 returns the divider, zero-extended.
- R5: When a pin's filter is disabled, its `pin_level` follows the pin exactly three clock edges after the pin changes: two synchronizer stages and one output register. Mode has no effect on this path.
- R6: In glitch mode, a new synchronized level reaches `pin_level` only after it has been seen on two consecutive system-clock samples. It appears four edges after a stable change at the pin. A pulse one cycle wide never reaches the output, while a pulse two cycles wide does.
- R7: In debounce mode, `pin_level` changes only in a cycle that carries a divided tick, and only to a level seen at two consecutive divided ticks. A level present at just one tick is dropped.
- R8: The divided tick falls on every 2 x (divider + 1)-th `slow_tick`, counted from the last divider write. A write to the divider restarts the count.
- R9: A write that actually changes a pin's mode discards that pin's previous sample. The filter then needs two fresh samples before it may update the output.
- R10: Writes to addresses 5 to 7 change nothing. Reads from any address other than 0, 2 and 4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | NPINS | Raw pin levels, asynchronous to `clk` |
| slow_tick | input | 1 | One-cycle strobe, one per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data or pin mask |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| pin_level | output | NPINS | Conditioned pin levels |

## Verification
The bench measures latency exactly. It looks at the output one edge before and one edge after each change is due, so a filter that adds or drops a register stage fails at once. It sends glitch pulses of one and two cycles, which separate a filter that needs two samples from one that needs a single sample. For dividers 0 to 3 it counts slow ticks one at a time, so a wrong period in the divider (for example div+1 in place of 2 x (div+1)) moves the output edge and is caught. It also checks that a level seen at only one tick is dropped, and that a mode toggle delays the update by a full tick pair. A design that kept the old sample after a mode change would update one tick pair too early.

// File: rtl/infilt_pkg.sv
package infilt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DEB_SET = 3'd2;
  localparam logic [ADDR_W-1:0] A_DEB_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV     = 3'd4;
endpackage

// File: rtl/infilt_sync.sv
module infilt_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/infilt_regs.sv
module infilt_regs
  import infilt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DIV_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  deb_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [NPINS-1:0]  restart,
  output logic              div_wr
);
  logic [NPINS-1:0] mask;
  logic             unused_wdata;

  assign mask         = wr_data[NPINS-1:0];
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      deb_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EN_SET:  en_q  <= en_q | mask;
        A_EN_CLR:  en_q  <= en_q & ~mask;
        A_DEB_SET: deb_q <= deb_q | mask;
        A_DEB_CLR: deb_q <= deb_q & ~mask;
        A_DIV:     div_q <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // Only pins whose mode actually flips are restarted.
  always_comb begin
    restart = '0;
    if (wr_en && wr_addr == A_DEB_SET) restart = mask & ~deb_q;
    if (wr_en && wr_addr == A_DEB_CLR) restart = mask & deb_q;
  end

  assign div_wr = wr_en && (wr_addr == A_DIV);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN_SET:  rd_data[NPINS-1:0] = en_q;
      A_DEB_SET: rd_data[NPINS-1:0] = deb_q;
      A_DIV:     rd_data[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/infilt_divider.sv
module infilt_divider #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [DIV_W-1:0] div_q,
  input  logic             div_wr,
  output logic             dtick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // Period of 2*(div+1) slow ticks: terminal count is 2*div+1.
  assign last  = {div_q, 1'b1};
  assign dtick = slow_tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (div_wr)    cnt <= '0;
    else if (dtick)     cnt <= '0;
    else if (slow_tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/infilt_cell.sv
module infilt_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic en,
  input  logic deb,
  input  logic dtick,
  input  logic restart,
  output logic lvl
);
  logic cand;
  logic primed;
  logic sample;

  assign sample = deb ? dtick : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= 1'b0;
      cand   <= 1'b0;
      primed <= 1'b0;
    end else if (!en) begin
      lvl    <= sync_lvl;
      cand   <= sync_lvl;
      primed <= ~restart;
    end else if (restart) begin
      cand   <= sync_lvl;
      primed <= 1'b0;
    end else if (sample) begin
      cand   <= sync_lvl;
      primed <= 1'b1;
      if (primed && (sync_lvl == cand)) lvl <= sync_lvl;
    end
  end
endmodule

// File: rtl/infilt_bank.sv
module infilt_bank
  import infilt_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int DIV_W       = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_async,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NPINS-1:0]  pin_level
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] deb_q;
  logic [DIV_W-1:0] div_q;
  logic [NPINS-1:0] restart;
  logic             div_wr;
  logic             dtick;

  infilt_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_async), .q(pin_sync)
  );

  infilt_regs #(.NPINS(NPINS), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .en_q(en_q), .deb_q(deb_q), .div_q(div_q), .restart(restart),
    .div_wr(div_wr)
  );

  infilt_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .div_q(div_q),
    .div_wr(div_wr), .dtick(dtick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    infilt_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sync_lvl(pin_sync[i]), .en(en_q[i]),
      .deb(deb_q[i]), .dtick(dtick), .restart(restart[i]),
      .lvl(pin_level[i])
    );
  end
endmodule

// File: rtl/infilt_checker.sv
module infilt_checker
  import infilt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DIV_W  = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  deb_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [NPINS-1:0]  pin_sync,
  input logic [NPINS-1:0]  pin_level,
  input logic              slow_tick,
  input logic              dtick,
  input logic              div_wr
);
  logic [DIV_W:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (div_wr)    seen <= '0;
    else if (slow_tick) seen <= dtick ? '0 : seen + 1'b1;
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EN_SET) |=>
      ((en_q & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0])));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EN_CLR) |=> ((en_q & $past(wr_data[NPINS-1:0])) == '0));

  assert_mode_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DEB_SET) |=>
      ((deb_q & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0])));

  assert_mode_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DEB_CLR) |=> ((deb_q & $past(wr_data[NPINS-1:0])) == '0));

  assert_div_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIV) |=> (div_q == $past(wr_data[DIV_W-1:0])));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_level ^ $past(pin_sync)) & ~$past(en_q)) == '0));

  assert_glitch_two_samples_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_level ^ $past(pin_level)) & $past(en_q & ~deb_q) &
      ((pin_level ^ $past(pin_sync)) | ($past(pin_sync) ^ $past(pin_sync, 2)))) == '0));

  assert_debounce_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dtick)) |-> (((pin_level ^ $past(pin_level)) & $past(en_q & deb_q)) == '0));

  assert_tick_on_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dtick |-> slow_tick);

  assert_tick_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dtick |-> (seen == {div_q, 1'b1}));
endmodule

bind infilt_bank infilt_checker #(.NPINS(NPINS), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en_q(en_q), .deb_q(deb_q), .div_q(div_q), .pin_sync(pin_sync),
  .pin_level(pin_level), .slow_tick(slow_tick), .dtick(dtick), .div_wr(div_wr)
);

// File: tb/sim_infilt_bank.sv
`timescale 1ns/1ps
module sim_infilt_bank;
  localparam int NP = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic          slow_tick;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [31:0]   wr_data;
  logic [2:0]    rd_addr;
  logic [31:0]   rd_data;
  logic [NP-1:0] lvl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  infilt_bank #(.NPINS(NP), .DIV_W(DW), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_async(pin), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_level(lvl)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [NP-1:0] prev, q, base;
    int t;
    rst_n = 1'b0; pin = '0; slow_tick = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd_chk("R1 enable", 3'd0, 32'h0);
    rd_chk("R1 mode", 3'd2, 32'h0);
    rd_chk("R1 divider", 3'd4, 32'h0);
    chk("R1 level", 32'(lvl), 32'h0);

    // R2 enable set/clear sweep
    for (int m = 0; m < 256; m++) begin
      wr(3'd1, 32'hFF);
      wr(3'd0, 32'(m));
      rd_chk("R2 set", 3'd0, 32'(m));
      wr(3'd1, 32'(m & 8'h0F));
      rd_chk("R2 clear", 3'd0, 32'(m & 8'hF0));
    end

    // R3 mode set/clear sweep
    for (int m = 0; m < 256; m++) begin
      wr(3'd3, 32'hFF);
      wr(3'd2, 32'(m));
      rd_chk("R3 set", 3'd2, 32'(m));
      wr(3'd3, 32'(m & 8'h3C));
      rd_chk("R3 clear", 3'd2, 32'(m & 8'hC3));
    end

    // R4 divider field
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R4 all ones", 3'd4, 32'hF);
    wr(3'd4, 32'h35);
    rd_chk("R4 truncate", 3'd4, 32'h5);

    // R10 unused addresses
    for (int a = 5; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    rd_chk("R10 enable kept", 3'd0, 32'hF0);
    rd_chk("R10 mode kept", 3'd2, 32'hC3);
    rd_chk("R10 divider kept", 3'd4, 32'h5);
    for (int a = 0; a < 8; a++)
      if (a % 2 == 1 || a > 4) rd_chk("R10 empty read", 3'(a), 32'h0);

    // R5 bypass sweep with exact latency
    wr(3'd1, 32'hFF);
    wr(3'd3, 32'hFF);
    wr(3'd4, 32'h0);
    step(4);
    prev = lvl;
    for (int p = 0; p < 256; p++) begin
      q = NP'((p * 73 + 5) & 255);
      pin = q;
      step(2);
      chk("R5 not before 3 edges", 32'(lvl), 32'(prev));
      step(1);
      chk("R5 after 3 edges", 32'(lvl), 32'(q));
      prev = q;
    end

    // R6 glitch filter
    wr(3'd0, 32'hFF);
    step(6);
    prev = lvl;
    for (int i = 0; i < 64; i++) begin
      q = NP'((i * 37 + 11) & 255);
      pin = q;
      step(3);
      chk("R6 not before 4 edges", 32'(lvl), 32'(prev));
      step(1);
      chk("R6 after 4 edges", 32'(lvl), 32'(q));
      prev = q;
    end
    base = prev;
    pin = ~base;
    step(1);
    pin = base;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R6 one-cycle pulse dropped", 32'(lvl), 32'(base));
    end
    pin = ~base;
    step(2);
    pin = base;
    step(2);
    chk("R6 two-cycle pulse passes", 32'(lvl), 32'(NP'(~base)));
    step(2);
    chk("R6 two-cycle pulse ends", 32'(lvl), 32'(base));

    // R7 / R8 debounce over dividers 0..3
    for (int d = 0; d < 4; d++) begin
      t = 2 * (d + 1);
      wr(3'd3, 32'hFF);
      pin = '0;
      step(6);
      wr(3'd4, 32'(d));
      wr(3'd2, 32'hFF);
      pin = 8'h5A;
      step(4);
      for (int k = 1; k <= 2 * t; k++) begin
        stick();
        if (k < 2 * t) chk("R8 no update before tick pair", 32'(lvl), 32'h0);
        else           chk("R8 update on second tick", 32'(lvl), 32'h5A);
      end
      pin = 8'hC3;
      step(4);
      for (int k = 0; k < t; k++) stick();
      pin = 8'h5A;
      step(4);
      for (int k = 0; k < 2 * t; k++) stick();
      chk("R7 single-tick level dropped", 32'(lvl), 32'h5A);
      pin = 8'h0F;
      step(4);
      for (int k = 1; k <= 2 * t; k++) begin
        stick();
        if (k == 2 * t - 1) chk("R7 held until tick", 32'(lvl), 32'h5A);
        if (k == 2 * t)     chk("R7 update on tick", 32'(lvl), 32'h0F);
      end
    end

    // R9 restart on mode change
    wr(3'd4, 32'h0);
    pin = 8'hF0;
    step(4);
    stick(); stick();
    wr(3'd3, 32'hFF);
    wr(3'd2, 32'hFF);
    chk("R9 no update on toggle", 32'(lvl), 32'h0F);
    stick(); stick();
    chk("R9 old sample discarded", 32'(lvl), 32'h0F);
    stick(); stick();
    chk("R9 fresh pair updates", 32'(lvl), 32'hF0);

    // R5 bypass while debounce is selected
    wr(3'd1, 32'hFF);
    pin = 8'h99;
    step(3);
    chk("R5 bypass in debounce mode", 32'(lvl), 32'h99);

    finish_run();
  end
endmodule